// File: doc/BRIEF.md
# Bridge Error Capture and Machine-Check Signaller

This block sits in a host bridge and gathers error-detect pulses from the processor interface, the PCI side and the message unit. It also accepts an external non-maskable interrupt request. The first error seen while no error is pending has its type code, origin, address-valid flag and address latched. Errors that follow only add their own detection bits. The captured record stays frozen until software has cleared every detection bit through a write-one-to-clear port.

For each enabled error, the block raises a machine-check request to the processor core. The request stays high until the processor reads the machine-check exception vector. The block also decodes unsupported processor transactions itself: writes into the PCI interrupt-acknowledge window, and any access made by an external-control instruction. For every processor-side error, it returns a transfer acknowledge so that the data tenure ends.

Bus protocols are reduced to single-cycle strobes. `cpu_rd` and `cpu_wr` each mark one processor access at `cpu_addr`.

Top module: `bridge_err_capture`

## Requirements
- R1: After reset, `det`, `cap_type`, `cap_pci`, `cap_noaddr`, `cap_addr`, `mchk` and `xfer_ack` are all zero.
- R2: An unsupported processor transaction is decoded into detection bit 0. It is either a `cpu_wr` whose address lies in the interrupt-acknowledge window, or a `cpu_rd` or `cpu_wr` with `cpu_xctl` high. The window is 0xBFFF_FFF0..0xBFFF_FFFF when `map_b`=0 and 0xFEF0_0000..0xFEFF_FFFF when `map_b`=1. Reads of the window are not errors, and neither are writes to the other map's window.
- R3: Each detection bit is set on the clock after its event and then stays set until cleared. Bit 0 is unsupported transaction, bit 1 `flash_err`, bit 2 `par_err`, bit 3 `pci_err` and bit 4 `msg_err`.
- R4: An event is captured when no detection bit would remain set after this cycle's clear. The capture is taken on the next clock. If several events arrive together, the lowest bit index wins. The recorded fields depend on the source:
  - bit 0: type 01, `cap_pci`=0, `cap_noaddr`=0, address `cpu_addr`.
  - bit 1: type 10, `cap_pci`=0, `cap_noaddr`=0, address `cpu_addr`.
  - bit 2: type 11, `cap_pci`=0, `cap_noaddr`=0, address `cpu_addr`.
  - bit 3: type 00, `cap_pci`=1, `cap_noaddr`=`pci_addr_bad`, address `pci_addr`.
  - bit 4: type 00, `cap_pci`=1, `cap_noaddr`=1, address 0.
- R5: While any detection bit stays set, later events leave the captured fields unchanged.
- R6: Writing `clr_we` with `clr_mask` clears the masked detection bits. An event arriving in the same cycle as the clear that empties the register is itself captured.
- R7: `mchk` rises on the clock after an event whose `rpt_en` bit is 1, provided the block is armed as in R4. An event whose `rpt_en` bit is 0 sets its detection bit but does not raise `mchk`.
- R8: `mchk` is not raised again while any detection bit remains set.
- R9: Once high, `mchk` stays high until a `cpu_rd` whose low 20 address bits are 0x00200. When `rom_on_pci`=1, a read with upper 12 bits 0xFFF does not negate it. A new raise in the same cycle as such a read takes priority.
- R10: `nmi_req` with `nmi_en`=1 raises `mchk` when the block is armed, without touching `det`. While any detection bit is set, it has no effect.
- R11: `xfer_ack` is high on the clock after any processor-side event (bits 0 to 2) when `ack_dis`=0, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Processor bus address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_xctl | input | 1 | Access is from an external-control instruction |
| map_b | input | 1 | Selects the alternate address map |
| rom_on_pci | input | 1 | Boot ROM space lives on the PCI side |
| ack_dis | input | 1 | Suppresses the transfer acknowledge on errors |
| flash_err | input | 1 | Flash write error pulse |
| par_err | input | 1 | Processor write parity error pulse |
| pci_err | input | 1 | PCI-side error pulse |
| pci_addr | input | 32 | Address belonging to `pci_err` |
| pci_addr_bad | input | 1 | `pci_addr` is not valid |
| msg_err | input | 1 | Message unit event pulse |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| rpt_en | input | 5 | Report enable for each detection bit |
| nmi_en | input | 1 | Report enable for `nmi_req` |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 5 | Detection bits to clear (write one to clear) |
| det | output | 5 | Detection bits |
| cap_type | output | 2 | Captured error type code |
| cap_pci | output | 1 | Captured origin, 1 = PCI side |
| cap_noaddr | output | 1 | Captured address is invalid |
| cap_addr | output | 32 | Captured error address |
| mchk | output | 1 | Machine-check request to the core |
| xfer_ack | output | 1 | Transfer acknowledge for a processor-side error |

## Verification
The hardest situation to reach is a clear that empties the detection register in the same cycle as a new event. The same cycle may also carry an exception-vector read while `mchk` is high. Every step of the stimulus is random, so clears, error pulses and vector reads overlap freely. The address generator also leans toward the vector address, the ROM alias and both interrupt-acknowledge windows, which makes these coincidences frequent. Directed sequences then force the exact cases: a clear together with a new event, an ignored ROM-alias read, and an NMI that arrives while a detection bit is pending.

// File: rtl/bridge_err_capture.sv
module bridge_err_capture #(
  parameter int          NDET     = 5,
  parameter logic [19:0] VEC_LOW  = 20'h00200,
  parameter logic [11:0] ROM_TOP  = 12'hFFF,
  parameter logic [27:0] IACK_A   = 28'hBFFF_FFF,
  parameter logic [11:0] IACK_B   = 12'hFEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     cpu_addr,
  input  logic            cpu_rd,
  input  logic            cpu_wr,
  input  logic            cpu_xctl,
  input  logic            map_b,
  input  logic            rom_on_pci,
  input  logic            ack_dis,
  input  logic            flash_err,
  input  logic            par_err,
  input  logic            pci_err,
  input  logic [31:0]     pci_addr,
  input  logic            pci_addr_bad,
  input  logic            msg_err,
  input  logic            nmi_req,
  input  logic [NDET-1:0] rpt_en,
  input  logic            nmi_en,
  input  logic            clr_we,
  input  logic [NDET-1:0] clr_mask,
  output logic [NDET-1:0] det,
  output logic [1:0]      cap_type,
  output logic            cap_pci,
  output logic            cap_noaddr,
  output logic [31:0]     cap_addr,
  output logic            mchk,
  output logic            xfer_ack
);

  logic            in_iack, unsup, armed, vec_rd, raise;
  logic [NDET-1:0] ev, keep;
  logic [1:0]      n_type;
  logic            n_pci, n_noaddr;
  logic [31:0]     n_addr;

  assign in_iack = map_b ? (cpu_addr[31:20] == IACK_B) : (cpu_addr[31:4] == IACK_A);
  assign unsup   = (cpu_wr && in_iack) || (cpu_xctl && (cpu_rd || cpu_wr));
  assign ev      = {msg_err, pci_err, par_err, flash_err, unsup};
  assign keep    = det & ~(clr_we ? clr_mask : '0);
  assign armed   = (keep == '0);
  assign vec_rd  = cpu_rd && (cpu_addr[19:0] == VEC_LOW)
                   && !(rom_on_pci && (cpu_addr[31:20] == ROM_TOP));
  assign raise   = armed && ((|(ev & rpt_en)) || (nmi_req && nmi_en));

  always_comb begin
    n_type = 2'b00; n_pci = 1'b1; n_noaddr = 1'b1; n_addr = '0;
    if (ev[0]) begin
      n_type = 2'b01; n_pci = 1'b0; n_noaddr = 1'b0; n_addr = cpu_addr;
    end else if (ev[1]) begin
      n_type = 2'b10; n_pci = 1'b0; n_noaddr = 1'b0; n_addr = cpu_addr;
    end else if (ev[2]) begin
      n_type = 2'b11; n_pci = 1'b0; n_noaddr = 1'b0; n_addr = cpu_addr;
    end else if (ev[3]) begin
      n_noaddr = pci_addr_bad; n_addr = pci_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det        <= '0;
      cap_type   <= '0;
      cap_pci    <= 1'b0;
      cap_noaddr <= 1'b0;
      cap_addr   <= '0;
      mchk       <= 1'b0;
      xfer_ack   <= 1'b0;
    end else begin
      det <= keep | ev;
      if (armed && (|ev)) begin
        cap_type   <= n_type;
        cap_pci    <= n_pci;
        cap_noaddr <= n_noaddr;
        cap_addr   <= n_addr;
      end
      mchk     <= raise | (mchk & ~vec_rd);
      xfer_ack <= (|ev[2:0]) & ~ack_dis;
    end
  end

  p_det_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((det & $past(det)) == $past(det)));

  p_capture_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det != '0 && !clr_we) |=> $stable({cap_type, cap_pci, cap_noaddr, cap_addr}));

  p_mchk_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mchk) |-> $past((|(ev & rpt_en)) || (nmi_req && nmi_en)));

  p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !$rose(mchk));

  p_mchk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mchk && !vec_rd) |=> mchk);

  p_nmi_no_det_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && ev == '0 && !clr_we) |=> (det == $past(det)));

  p_ack_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> $past(!ack_dis && (|ev[2:0])));

endmodule

// File: tb/bridge_err_capture_tb.sv
module bridge_err_capture_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cpu_addr = '0, pci_addr = '0;
  logic cpu_rd = 0, cpu_wr = 0, cpu_xctl = 0, map_b = 0, rom_on_pci = 0, ack_dis = 0;
  logic flash_err = 0, par_err = 0, pci_err = 0, pci_addr_bad = 0, msg_err = 0, nmi_req = 0;
  logic nmi_en = 0, clr_we = 0;
  logic [4:0] rpt_en = '0, clr_mask = '0;
  logic [4:0] det;
  logic [1:0] cap_type;
  logic cap_pci, cap_noaddr, mchk, xfer_ack;
  logic [31:0] cap_addr;

  logic [4:0]  e_det = '0;
  logic [1:0]  e_type = '0;
  logic        e_pci = 0, e_noaddr = 0, e_mchk = 0, e_ack = 0;
  logic [31:0] e_addr = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_err_capture u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic unsup_f();
    logic win;
    win = map_b ? (cpu_addr[31:20] == 12'hFEF) : (cpu_addr[31:4] == 28'hBFFFFFF);
    return (cpu_wr && win) || (cpu_xctl && (cpu_rd || cpu_wr));
  endfunction

  task automatic model();
    logic [4:0] ev, rem;
    logic armed, vread, up;
    ev = {msg_err, pci_err, par_err, flash_err, unsup_f()};
    rem = e_det & ~(clr_we ? clr_mask : 5'd0);
    armed = (rem == 0);
    if (armed && ev != 0) begin
      if (ev[0])      begin e_type = 2'b01; e_pci = 0; e_noaddr = 0; e_addr = cpu_addr; end
      else if (ev[1]) begin e_type = 2'b10; e_pci = 0; e_noaddr = 0; e_addr = cpu_addr; end
      else if (ev[2]) begin e_type = 2'b11; e_pci = 0; e_noaddr = 0; e_addr = cpu_addr; end
      else if (ev[3]) begin e_type = 2'b00; e_pci = 1; e_noaddr = pci_addr_bad; e_addr = pci_addr; end
      else            begin e_type = 2'b00; e_pci = 1; e_noaddr = 1; e_addr = '0; end
    end
    e_det = rem | ev;
    vread = cpu_rd && cpu_addr[19:0] == 20'h00200 && !(rom_on_pci && cpu_addr[31:20] == 12'hFFF);
    up = armed && (((ev & rpt_en) != 0) || (nmi_req && nmi_en));
    e_mchk = up ? 1'b1 : (vread ? 1'b0 : e_mchk);
    e_ack = (ev[2:0] != 0) && !ack_dis;
  endtask

  task automatic idle();
    cpu_rd = 0; cpu_wr = 0; cpu_xctl = 0; flash_err = 0; par_err = 0;
    pci_err = 0; msg_err = 0; nmi_req = 0; clr_we = 0; clr_mask = 0;
  endtask

  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    chk("R3 det", det, e_det);
    chk("R4 R5 capture", {cap_type, cap_pci, cap_noaddr, cap_addr},
        {e_type, e_pci, e_noaddr, e_addr});
    chk("R9 mchk", mchk, e_mchk);
    chk("R11 xfer_ack", xfer_ack, e_ack);
    idle();
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom_range(0, 6))
      0: return {28'hBFFFFFF, 4'($urandom)};
      1: return {12'hFEF, 20'($urandom)};
      2: return 32'h0000_0200;
      3: return 32'hFFF0_0200;
      4: return {12'($urandom), 20'h00200};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset det", det, 0);
    chk("R1 reset capture", {cap_type, cap_pci, cap_noaddr, cap_addr}, 0);
    chk("R1 reset mchk/ack", {mchk, xfer_ack}, 0);
    rst_n = 1;
    rpt_en = 5'h1F; nmi_en = 1;

    cpu_wr = 1; cpu_addr = 32'hBFFF_FFF4; step();
    chk("R2 iack write map A", det, 5'b00001);
    chk("R4 unsup capture", {cap_type, cap_pci, cap_noaddr, cap_addr}, {2'b01, 2'b00, 32'hBFFF_FFF4});
    chk("R7 mchk raised", mchk, 1);
    chk("R11 ack", xfer_ack, 1);

    pci_err = 1; pci_addr = 32'h1234_5678; step();
    chk("R5 frozen on later error", cap_addr, 32'hBFFF_FFF4);
    chk("R3 accumulate", det, 5'b01001);

    rom_on_pci = 1; cpu_rd = 1; cpu_addr = 32'hFFF0_0200; step();
    chk("R9 ROM alias read ignored", mchk, 1);
    cpu_rd = 1; cpu_addr = 32'h0000_0200; step();
    chk("R9 vector read negates", mchk, 0);
    rom_on_pci = 0;

    msg_err = 1; step();
    chk("R8 no re-raise while pending", mchk, 0);

    clr_we = 1; clr_mask = 5'b11000; step();
    chk("R6 partial clear", det, 5'b00001);
    ack_dis = 1; clr_we = 1; clr_mask = 5'b00001; flash_err = 1; cpu_addr = 32'h0000_4000; step();
    chk("R6 clear with event captured", {det, cap_type, cap_addr}, {5'b00010, 2'b10, 32'h0000_4000});
    chk("R7 raised after re-arm", mchk, 1);
    chk("R11 ack disabled", xfer_ack, 0);
    ack_dis = 0;

    clr_we = 1; clr_mask = 5'h1F; cpu_rd = 1; cpu_addr = 32'h0000_0200; step();
    nmi_req = 1; step();
    chk("R10 nmi raises without det", {mchk, det}, {1'b1, 5'b0});
    cpu_rd = 1; cpu_addr = 32'h0000_0200; step();
    nmi_en = 0; nmi_req = 1; step();
    chk("R10 nmi disabled", mchk, 0);
    nmi_en = 1;

    rpt_en = 5'b0; par_err = 1; step();
    chk("R7 disabled error no mchk", {mchk, det}, {1'b0, 5'b00100});
    nmi_req = 1; step();
    chk("R10 nmi masked by pending det", mchk, 0);
    rpt_en = 5'h1F;

    clr_we = 1; clr_mask = 5'h1F; step();
    map_b = 1; cpu_wr = 1; cpu_addr = 32'hBFFF_FFF4; step();
    chk("R2 map A window ignored under map B", det, 0);
    cpu_wr = 1; cpu_addr = 32'hFEF1_2345; step();
    chk("R2 iack write map B", det, 5'b00001);
    clr_we = 1; clr_mask = 5'h1F; cpu_rd = 1; cpu_addr = 32'h0000_0200; step();
    map_b = 0; cpu_rd = 1; cpu_addr = 32'hBFFF_FFF8; step();
    chk("R2 iack read not error", det, 0);
    cpu_rd = 1; cpu_xctl = 1; cpu_addr = 32'h0000_1000; step();
    chk("R2 ext-control read", det, 5'b00001);

    clr_we = 1; clr_mask = 5'h1F; step();
    pci_err = 1; msg_err = 1; pci_addr = 32'hCAFE_0000; pci_addr_bad = 1; step();
    chk("R4 pci priority over msg", {cap_type, cap_pci, cap_noaddr, cap_addr}, {2'b00, 2'b11, 32'hCAFE_0000});
    pci_addr_bad = 0;

    for (int i = 0; i < 4000; i++) begin
      cpu_addr = pick_addr();
      case ($urandom_range(0, 3))
        0: cpu_rd = 1;
        1: cpu_wr = 1;
        default: ;
      endcase
      cpu_xctl = ($urandom_range(0, 15) == 0);
      map_b = $urandom_range(0, 1);
      rom_on_pci = $urandom_range(0, 1);
      ack_dis = ($urandom_range(0, 3) == 0);
      flash_err = ($urandom_range(0, 11) == 0);
      par_err = ($urandom_range(0, 11) == 0);
      pci_err = ($urandom_range(0, 9) == 0);
      pci_addr = $urandom;
      pci_addr_bad = $urandom_range(0, 1);
      msg_err = ($urandom_range(0, 11) == 0);
      nmi_req = ($urandom_range(0, 9) == 0);
      nmi_en = $urandom_range(0, 1);
      rpt_en = 5'($urandom);
      clr_we = ($urandom_range(0, 2) == 0);
      clr_mask = ($urandom_range(0, 1) == 0) ? 5'h1F : 5'($urandom);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule